// File: doc/BRIEF.md
# Miss and Writeback Issue Arbiter

The block chooses which memory request a cache controller sends downstream next. Requests wait in two small tables. One holds outstanding misses and the other holds buffered writebacks. Each slot stores a line address, a secure bit, an age stamp, a ready flag and an in-service flag. Age stamps come from one counter shared by both tables and are assigned when a slot is allocated. Each table offers its oldest ready, not-yet-issued entry as a candidate.

The arbiter keeps order between a miss and a writeback that target the same line. After it picks a side, it searches the other table for a pending entry with the same line address and secure bit. It searches every valid entry that is not in service, whether or not that entry is ready. If the match is older than the chosen candidate, the match is issued first. The issue port is combinational in the current state and uses a valid/ready handshake. An entry becomes in service when its handshake completes and is freed by a retire pulse that carries its slot index.

Top module: `miss_wb_arbiter`

## Requirements
- R1: After reset, both tables are empty: `iss_valid_o` is 0, both full flags are 0 and both next-free indices are 0.
- R2: Within one table, the candidate is the ready, valid, not-in-service entry with the oldest age stamp. A ready flag set later through the ready-set port makes a waiting entry eligible.
- R3: When both tables have a ready candidate and the writeback table is not full, the miss candidate is selected (`iss_wb_o`=0).
- R4: When only the writeback table has a ready candidate, the writeback candidate is selected (`iss_wb_o`=1).
- R5: When the writeback table is full and none of its entries is in service, a ready writeback is selected even though a ready miss exists.
- R6: When the writeback table is full but one of its entries is in service, the ready miss is selected again.
- R7: When a writeback is selected and the miss table holds an older pending entry with the same address and secure bit, that miss is issued instead, even if its ready flag is clear.
- R8: When a miss is selected and the writeback table holds an older pending entry with the same address and secure bit, that writeback is issued instead, even if its ready flag is clear.
- R9: A matching entry in the other table that differs in the secure bit, or that is younger than the candidate, does not redirect the issue.
- R10: A completed handshake marks the issued entry in service. In-service entries are neither candidates nor conflicts. A retire frees the slot, and the lowest free slot index is offered for the next allocation.
- R11: `iss_valid_o` stays 0 while neither table has a ready, not-in-service entry, even if entries are pending.
- R12: The full flag is set when every slot of a table is valid. An allocation into a full table is ignored.
- R13: While `iss_ready_i` is 0 and the tables do not change, the offered request stays valid and unchanged and no entry is marked in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_alloc_i | input | 1 | Allocate a miss entry at `m_alloc_idx_o` |
| m_alloc_addr_i | input | ADDR_W | Line address of the new miss |
| m_alloc_sec_i | input | 1 | Secure bit of the new miss |
| m_alloc_rdy_i | input | 1 | Ready flag of the new miss |
| m_alloc_idx_o | output | IDX_W | Lowest free miss slot |
| m_full_o | output | 1 | All miss slots are valid |
| m_rdy_set_i | input | 1 | Set the ready flag of miss slot `m_rdy_idx_i` |
| m_rdy_idx_i | input | IDX_W | Miss slot for the ready set |
| m_retire_i | input | 1 | Free miss slot `m_retire_idx_i` |
| m_retire_idx_i | input | IDX_W | Miss slot to free |
| w_alloc_i | input | 1 | Allocate a writeback entry at `w_alloc_idx_o` |
| w_alloc_addr_i | input | ADDR_W | Line address of the new writeback |
| w_alloc_sec_i | input | 1 | Secure bit of the new writeback |
| w_alloc_rdy_i | input | 1 | Ready flag of the new writeback |
| w_alloc_idx_o | output | IDX_W | Lowest free writeback slot |
| w_full_o | output | 1 | All writeback slots are valid |
| w_rdy_set_i | input | 1 | Set the ready flag of writeback slot `w_rdy_idx_i` |
| w_rdy_idx_i | input | IDX_W | Writeback slot for the ready set |
| w_retire_i | input | 1 | Free writeback slot `w_retire_idx_i` |
| w_retire_idx_i | input | IDX_W | Writeback slot to free |
| iss_valid_o | output | 1 | A request is offered downstream |
| iss_ready_i | input | 1 | Downstream accepts the offered request |
| iss_wb_o | output | 1 | Source table of the offer: 0 miss, 1 writeback |
| iss_idx_o | output | IDX_W | Slot index of the offer |
| iss_addr_o | output | ADDR_W | Line address of the offer |
| iss_sec_o | output | 1 | Secure bit of the offer |

## Verification
Selection is exercised with misses alone, writebacks alone, and both sides ready with the writeback table partly full, full and idle, or full with one entry in service. These cases separate the default miss preference from the full-table override. Conflict cases place a non-ready older entry on the opposite side, once behind a writeback candidate and once behind a miss candidate. This shows that the search ignores the ready flag. Control cases with a secure-bit mismatch and with a younger match confirm that only a true older conflict redirects the issue. A held handshake, an allocation into a full table and a late ready-set show the effect of each at the issue port.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  typedef enum logic {
    SRC_MISS = 1'b0,
    SRC_WB   = 1'b1
  } src_e;
endpackage

// File: rtl/mwa_age_pick.sv
// Finds the oldest masked slot; age order is wrap-safe (signed difference).
module mwa_age_pick #(
  parameter  int N     = 4,
  parameter  int AGE_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       mask_i,
  input  logic [N*AGE_W-1:0] age_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [AGE_W-1:0]   age_o
);

  function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    age_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && (!found_o || is_older(age_i[i*AGE_W +: AGE_W], age_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        age_o   = age_i[i*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/mwa_req_table.sv
module mwa_req_table #(
  parameter  int N      = 4,
  parameter  int ADDR_W = 32,
  parameter  int AGE_W  = 8,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic [ADDR_W-1:0]   alloc_addr_i,
  input  logic                alloc_sec_i,
  input  logic                alloc_rdy_i,
  input  logic [AGE_W-1:0]    alloc_age_i,
  input  logic                rdy_set_i,
  input  logic [IDX_W-1:0]    rdy_idx_i,
  input  logic                issue_i,
  input  logic [IDX_W-1:0]    issue_idx_i,
  input  logic                retire_i,
  input  logic [IDX_W-1:0]    retire_idx_i,
  output logic                full_o,
  output logic [IDX_W-1:0]    free_idx_o,
  output logic [N-1:0]        valid_o,
  output logic [N-1:0]        rdy_o,
  output logic [N-1:0]        svc_o,
  output logic [N-1:0]        sec_o,
  output logic [N*ADDR_W-1:0] addr_o,
  output logic [N*AGE_W-1:0]  age_o
);

  logic              valid_q [N];
  logic              rdy_q   [N];
  logic              svc_q   [N];
  logic              sec_q   [N];
  logic [ADDR_W-1:0] addr_q  [N];
  logic [AGE_W-1:0]  age_q   [N];
  logic              take;

  assign full_o = &valid_o;
  assign take   = alloc_i && !full_o;

  always_comb begin
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx_o = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [IDX_W-1:0] ME = IDX_W'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        rdy_q[g]   <= 1'b0;
        svc_q[g]   <= 1'b0;
        sec_q[g]   <= 1'b0;
        addr_q[g]  <= '0;
        age_q[g]   <= '0;
      end else begin
        if (take && free_idx_o == ME) begin
          valid_q[g] <= 1'b1;
          rdy_q[g]   <= alloc_rdy_i;
          svc_q[g]   <= 1'b0;
          sec_q[g]   <= alloc_sec_i;
          addr_q[g]  <= alloc_addr_i;
          age_q[g]   <= alloc_age_i;
        end else begin
          if (rdy_set_i && rdy_idx_i == ME && valid_q[g]) rdy_q[g] <= 1'b1;
          if (issue_i && issue_idx_i == ME) svc_q[g] <= 1'b1;
        end
        if (retire_i && retire_idx_i == ME) begin
          valid_q[g] <= 1'b0;
          rdy_q[g]   <= 1'b0;
          svc_q[g]   <= 1'b0;
        end
      end
    end

    assign valid_o[g]                   = valid_q[g];
    assign rdy_o[g]                     = rdy_q[g];
    assign svc_o[g]                     = svc_q[g];
    assign sec_o[g]                     = sec_q[g];
    assign addr_o[g*ADDR_W +: ADDR_W]   = addr_q[g];
    assign age_o[g*AGE_W +: AGE_W]      = age_q[g];
  end

  // R10: issue only targets a pending slot
  a_r10_issue_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> valid_o[issue_idx_i] && !svc_o[issue_idx_i]);

  // R10: completed handshake leaves the slot in service
  a_r10_issue_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !(retire_i && retire_idx_i == issue_idx_i) |=> svc_o[$past(issue_idx_i)]);

  // R12: allocation into a full table changes nothing
  a_r12_full_alloc_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && alloc_i && !retire_i |=> $stable(valid_o) && $stable(addr_o));

endmodule

// File: rtl/miss_wb_arbiter.sv
module miss_wb_arbiter #(
  parameter  int DEPTH  = 4,
  parameter  int ADDR_W = 32,
  parameter  int AGE_W  = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m_alloc_i,
  input  logic [ADDR_W-1:0] m_alloc_addr_i,
  input  logic              m_alloc_sec_i,
  input  logic              m_alloc_rdy_i,
  output logic [IDX_W-1:0]  m_alloc_idx_o,
  output logic              m_full_o,
  input  logic              m_rdy_set_i,
  input  logic [IDX_W-1:0]  m_rdy_idx_i,
  input  logic              m_retire_i,
  input  logic [IDX_W-1:0]  m_retire_idx_i,
  input  logic              w_alloc_i,
  input  logic [ADDR_W-1:0] w_alloc_addr_i,
  input  logic              w_alloc_sec_i,
  input  logic              w_alloc_rdy_i,
  output logic [IDX_W-1:0]  w_alloc_idx_o,
  output logic              w_full_o,
  input  logic              w_rdy_set_i,
  input  logic [IDX_W-1:0]  w_rdy_idx_i,
  input  logic              w_retire_i,
  input  logic [IDX_W-1:0]  w_retire_idx_i,
  output logic              iss_valid_o,
  input  logic              iss_ready_i,
  output logic              iss_wb_o,
  output logic [IDX_W-1:0]  iss_idx_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  output logic              iss_sec_o
);
  import mwa_pkg::*;

  logic [AGE_W-1:0] ctr_q;
  logic             m_take, w_take;
  logic [AGE_W-1:0] m_age_new, w_age_new;

  logic [DEPTH-1:0]        m_valid, m_rdy, m_svc, m_sec;
  logic [DEPTH-1:0]        w_valid, w_rdy, w_svc, w_sec;
  logic [DEPTH*ADDR_W-1:0] m_addr, w_addr;
  logic [DEPTH*AGE_W-1:0]  m_age, w_age;

  logic             m_has, w_has, m_cf_found, w_cf_found;
  logic [IDX_W-1:0] m_cand, w_cand, m_cf_idx, w_cf_idx;
  logic [AGE_W-1:0] m_cand_age, w_cand_age, m_cf_age, w_cf_age;
  logic [DEPTH-1:0] m_hit, w_hit;
  logic [AGE_W-1:0] m_cf_diff, w_cf_diff;
  logic             m_cf_older, w_cf_older;
  logic             pick_wb, fire;
  src_e             src;

  // shared age stamps: a miss and a writeback allocated together get consecutive stamps
  assign m_take    = m_alloc_i && !m_full_o;
  assign w_take    = w_alloc_i && !w_full_o;
  assign m_age_new = ctr_q;
  assign w_age_new = ctr_q + AGE_W'(m_take);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctr_q <= '0;
    else         ctr_q <= ctr_q + AGE_W'(m_take) + AGE_W'(w_take);
  end

  mwa_req_table #(.N(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_miss_tab (
    .clk_i, .rst_ni,
    .alloc_i(m_alloc_i), .alloc_addr_i(m_alloc_addr_i), .alloc_sec_i(m_alloc_sec_i),
    .alloc_rdy_i(m_alloc_rdy_i), .alloc_age_i(m_age_new),
    .rdy_set_i(m_rdy_set_i), .rdy_idx_i(m_rdy_idx_i),
    .issue_i(fire && src == SRC_MISS), .issue_idx_i(iss_idx_o),
    .retire_i(m_retire_i), .retire_idx_i(m_retire_idx_i),
    .full_o(m_full_o), .free_idx_o(m_alloc_idx_o),
    .valid_o(m_valid), .rdy_o(m_rdy), .svc_o(m_svc), .sec_o(m_sec),
    .addr_o(m_addr), .age_o(m_age)
  );

  mwa_req_table #(.N(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_wb_tab (
    .clk_i, .rst_ni,
    .alloc_i(w_alloc_i), .alloc_addr_i(w_alloc_addr_i), .alloc_sec_i(w_alloc_sec_i),
    .alloc_rdy_i(w_alloc_rdy_i), .alloc_age_i(w_age_new),
    .rdy_set_i(w_rdy_set_i), .rdy_idx_i(w_rdy_idx_i),
    .issue_i(fire && src == SRC_WB), .issue_idx_i(iss_idx_o),
    .retire_i(w_retire_i), .retire_idx_i(w_retire_idx_i),
    .full_o(w_full_o), .free_idx_o(w_alloc_idx_o),
    .valid_o(w_valid), .rdy_o(w_rdy), .svc_o(w_svc), .sec_o(w_sec),
    .addr_o(w_addr), .age_o(w_age)
  );

  // per-table ready candidates
  mwa_age_pick #(.N(DEPTH), .AGE_W(AGE_W)) u_m_cand (
    .mask_i(m_valid & m_rdy & ~m_svc), .age_i(m_age),
    .found_o(m_has), .idx_o(m_cand), .age_o(m_cand_age)
  );

  mwa_age_pick #(.N(DEPTH), .AGE_W(AGE_W)) u_w_cand (
    .mask_i(w_valid & w_rdy & ~w_svc), .age_i(w_age),
    .found_o(w_has), .idx_o(w_cand), .age_o(w_cand_age)
  );

  // conflict search: every pending entry, ready or not
  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign m_hit[g] = m_valid[g] && !m_svc[g] && (m_sec[g] == w_sec[w_cand]) &&
                      (m_addr[g*ADDR_W +: ADDR_W] == w_addr[w_cand*ADDR_W +: ADDR_W]);
    assign w_hit[g] = w_valid[g] && !w_svc[g] && (w_sec[g] == m_sec[m_cand]) &&
                      (w_addr[g*ADDR_W +: ADDR_W] == m_addr[m_cand*ADDR_W +: ADDR_W]);
  end

  mwa_age_pick #(.N(DEPTH), .AGE_W(AGE_W)) u_m_cf (
    .mask_i(m_hit), .age_i(m_age),
    .found_o(m_cf_found), .idx_o(m_cf_idx), .age_o(m_cf_age)
  );

  mwa_age_pick #(.N(DEPTH), .AGE_W(AGE_W)) u_w_cf (
    .mask_i(w_hit), .age_i(w_age),
    .found_o(w_cf_found), .idx_o(w_cf_idx), .age_o(w_cf_age)
  );

  assign m_cf_diff  = m_cf_age - w_cand_age;
  assign w_cf_diff  = w_cf_age - m_cand_age;
  assign m_cf_older = m_cf_found && m_cf_diff[AGE_W-1];
  assign w_cf_older = w_cf_found && w_cf_diff[AGE_W-1];

  // full idle write table overrides the default miss preference
  assign pick_wb = w_has && ((w_full_o && !(|(w_valid & w_svc))) || !m_has);

  always_comb begin
    src       = SRC_MISS;
    iss_idx_o = m_cand;
    if (pick_wb) begin
      if (m_cf_older) begin
        src       = SRC_MISS;
        iss_idx_o = m_cf_idx;
      end else begin
        src       = SRC_WB;
        iss_idx_o = w_cand;
      end
    end else if (w_cf_older) begin
      src       = SRC_WB;
      iss_idx_o = w_cf_idx;
    end
  end

  assign iss_valid_o = m_has || w_has;
  assign iss_wb_o    = (src == SRC_WB);
  assign iss_addr_o  = iss_wb_o ? w_addr[iss_idx_o*ADDR_W +: ADDR_W]
                                : m_addr[iss_idx_o*ADDR_W +: ADDR_W];
  assign iss_sec_o   = iss_wb_o ? w_sec[iss_idx_o] : m_sec[iss_idx_o];
  assign fire        = iss_valid_o && iss_ready_i;

  // R11: nothing ready in either table means no offer
  a_r11_idle_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(m_valid & m_rdy & ~m_svc)) && !(|(w_valid & w_rdy & ~w_svc)) |-> !iss_valid_o);

  // R13: a stalled offer holds while the tables are untouched
  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && !iss_ready_i && !m_alloc_i && !w_alloc_i && !m_rdy_set_i &&
    !w_rdy_set_i && !m_retire_i && !w_retire_i
    |=> iss_valid_o && $stable(iss_wb_o) && $stable(iss_idx_o) && $stable(iss_addr_o));

  // R7: an issued writeback never has an older pending same-line miss
  a_r7_wb_after_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && iss_wb_o |-> !m_cf_older || !pick_wb);

endmodule

// File: tb/miss_wb_arbiter_test.sv
`timescale 1ns/1ps
module miss_wb_arbiter_test;
  localparam int DEPTH = 4, ADDR_W = 32, IDX_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic m_alloc_i = 0, m_alloc_sec_i = 0, m_alloc_rdy_i = 0, m_rdy_set_i = 0, m_retire_i = 0;
  logic w_alloc_i = 0, w_alloc_sec_i = 0, w_alloc_rdy_i = 0, w_rdy_set_i = 0, w_retire_i = 0;
  logic [ADDR_W-1:0] m_alloc_addr_i = '0, w_alloc_addr_i = '0;
  logic [IDX_W-1:0]  m_rdy_idx_i = '0, m_retire_idx_i = '0, w_rdy_idx_i = '0, w_retire_idx_i = '0;
  logic [IDX_W-1:0]  m_alloc_idx_o, w_alloc_idx_o, iss_idx_o;
  logic              m_full_o, w_full_o, iss_valid_o, iss_wb_o, iss_sec_o;
  logic              iss_ready_i = 0;
  logic [ADDR_W-1:0] iss_addr_o;

  int checks = 0, errors = 0;

  typedef struct {
    bit          wb;
    int          idx;
    logic [31:0] addr;
    string       req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  miss_wb_arbiter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(8)) uut (.*);

  // monitor: every completed handshake is compared with the scoreboard head
  always @(negedge clk_i) begin
    if (rst_ni && iss_valid_o && iss_ready_i) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected issue: actual wb=%0d idx=%0d addr=%h expected none",
                 iss_wb_o, iss_idx_o, iss_addr_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (iss_wb_o !== e.wb || int'(iss_idx_o) != e.idx || iss_addr_o !== e.addr) begin
          errors++;
          $display("FAIL %s: actual wb=%0d idx=%0d addr=%h expected wb=%0d idx=%0d addr=%h",
                   e.req, iss_wb_o, iss_idx_o, iss_addr_o, e.wb, e.idx, e.addr);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    q.delete();
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic m_alloc(logic [31:0] a, bit s, bit r);
    m_alloc_i = 1; m_alloc_addr_i = a; m_alloc_sec_i = s; m_alloc_rdy_i = r;
    tick();
    m_alloc_i = 0;
  endtask

  task automatic w_alloc(logic [31:0] a, bit s, bit r);
    w_alloc_i = 1; w_alloc_addr_i = a; w_alloc_sec_i = s; w_alloc_rdy_i = r;
    tick();
    w_alloc_i = 0;
  endtask

  // driver: push the expected item, accept for one cycle, confirm it was consumed
  task automatic take(bit wb, int idx, logic [31:0] a, string req);
    exp_t e;
    e.wb = wb; e.idx = idx; e.addr = a; e.req = req;
    q.push_back(e);
    iss_ready_i = 1;
    tick();
    iss_ready_i = 0;
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL %s: actual no issue expected wb=%0d idx=%0d addr=%h", req, wb, idx, a);
      q.delete();
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 valid", int'(iss_valid_o), 0);
    check("R1 full", int'(m_full_o) + int'(w_full_o), 0);
    check("R1 free idx", int'(m_alloc_idx_o) + int'(w_alloc_idx_o), 0);

    // R2 / R11 / R10: oldest ready miss, pending non-ready is not offered
    m_alloc(32'hA0, 0, 0);
    check("R11 pending not ready", int'(iss_valid_o), 0);
    m_alloc(32'hB0, 0, 1);
    m_alloc(32'hC0, 0, 1);
    check("R10 next free", int'(m_alloc_idx_o), 3);
    take(0, 1, 32'hB0, "R2 oldest ready");
    take(0, 2, 32'hC0, "R10 in service skipped");
    check("R11 only non-ready left", int'(iss_valid_o), 0);
    m_retire_i = 1; m_retire_idx_i = 2'd1; tick(); m_retire_i = 0;
    check("R10 retire frees slot", int'(m_alloc_idx_o), 1);
    m_rdy_set_i = 1; m_rdy_idx_i = 2'd0; tick(); m_rdy_set_i = 0;
    take(0, 0, 32'hA0, "R2 ready set");

    // R3 / R4: miss preferred, then writeback alone
    do_reset();
    w_alloc(32'h100, 0, 1);
    m_alloc(32'h200, 0, 1);
    take(0, 0, 32'h200, "R3 miss preferred");
    take(1, 0, 32'h100, "R4 writeback alone");

    // R5 / R6 / R12: full writeback table
    do_reset();
    for (int i = 0; i < DEPTH; i++) w_alloc(32'h10 + i, 0, 1);
    check("R12 full flag", int'(w_full_o), 1);
    w_alloc(32'h77, 0, 1);
    m_alloc(32'h50, 0, 1);
    take(1, 0, 32'h10, "R5 full idle write table");
    take(0, 0, 32'h50, "R6 full with one in service");
    take(1, 1, 32'h11, "R4 drain");
    take(1, 2, 32'h12, "R4 drain");
    take(1, 3, 32'h13, "R4 drain");
    check("R12 alloc when full ignored", int'(iss_valid_o), 0);

    // R7: older non-ready miss issued before writeback
    do_reset();
    m_alloc(32'h300, 0, 0);
    w_alloc(32'h300, 0, 1);
    take(0, 0, 32'h300, "R7 older miss first");
    take(1, 0, 32'h300, "R10 in service not a conflict");

    // R8: older non-ready writeback issued before miss
    do_reset();
    w_alloc(32'h400, 0, 0);
    m_alloc(32'h400, 0, 1);
    take(1, 0, 32'h400, "R8 older writeback first");
    take(0, 0, 32'h400, "R8 miss after writeback");

    // R9: secure mismatch and younger match do not redirect
    do_reset();
    w_alloc(32'h500, 1, 0);
    m_alloc(32'h500, 0, 1);
    take(0, 0, 32'h500, "R9 secure mismatch");
    check("R11 after R9", int'(iss_valid_o), 0);
    do_reset();
    m_alloc(32'h600, 0, 1);
    w_alloc(32'h600, 0, 0);
    take(0, 0, 32'h600, "R9 younger match");

    // R13: stalled offer holds
    do_reset();
    m_alloc(32'h700, 0, 1);
    for (int i = 0; i < 3; i++) begin
      check("R13 hold valid", int'(iss_valid_o), 1);
      check("R13 hold addr", int'(iss_addr_o), 32'h700);
      tick();
    end
    take(0, 0, 32'h700, "R13 issue after stall");
    check("R13 issued once", int'(iss_valid_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule